// File: doc/BRIEF.md
# Masked Address/Data Break Comparator

This block is a single channel of a hardware breakpoint unit. It watches every bus cycle that the processor side announces with a valid strobe. When the cycle address matches a programmed break address, it raises a one-clock break request. A per-bit mask lets some address bits take no part in the comparison. The data word of the cycle can also be required to match a programmed data value.

The data operand comes from one of four monitored sources: two 32-bit buses and two 16-bit memory ports. The 16-bit X port is compared against the upper half of the break data register, and the 16-bit Y port against the lower half. The other half of the register plays no part while that port is selected.

Software programs the channel through a small register port. It has a write enable, a word offset and write data. Readback is combinational on the same offset.

Top module: `brk_cmp`

## Requirements
- R1: After reset, every register reads zero and `brk_pulse` is low.
- R2: Register map by `reg_addr`:
  - offset 0 is the break address.
  - offset 1 is the address mask.
  - offset 2 is the break data.
  - offset 3 is the control word: bits [1:0] source code, bit 2 memory-port enable, bit 3 port pick (0 = X, 1 = Y), bit 4 data-compare enable.

  A write takes effect at the clock edge. It is read back unchanged, except that control bits above bit 4 always read zero.
- R3: An address bit whose mask bit is 1 does not affect the match.
- R4: An address bit whose mask bit is 0 must equal the break address bit for a match.
- R5: `brk_pulse` is high in the cycle right after a clock edge that samples `cyc_valid` high with a satisfied condition, and it stays high for one clock only. A matching cycle with `cyc_valid` low gives no pulse.
- R6: With the memory-port enable at 0, the source code selects the 32-bit bus as follows: code 00 selects `bus_a_data` and code 01 selects `bus_b_data`. The whole 32-bit break data word is compared with the selected bus.
- R7: With the X port selected, `mem_x_data` is compared with break data bits 31..16. Bits 15..0 are ignored.
- R8: With the Y port selected, `mem_y_data` is compared with break data bits 15..0. Bits 31..16 are ignored.
- R9: With data-compare enable at 0, the address match alone fires the break, whatever the data inputs and source fields hold.
- R10: With data-compare enable at 1, memory-port enable at 0 and source code 1x, no source is selected and no break fires.
- R11: Offsets 4 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cyc_valid | input | 1 | Bus cycle valid strobe |
| cyc_addr | input | 32 | Bus cycle address |
| bus_a_data | input | 32 | First 32-bit data bus |
| bus_b_data | input | 32 | Second 32-bit data bus |
| mem_x_data | input | 16 | X memory port data |
| mem_y_data | input | 16 | Y memory port data |
| brk_pulse | output | 1 | Registered one-clock break request |

## Verification
The comparator is driven with several kinds of address patterns:
- patterns that differ only in masked bits, which separates masked from compared bits;
- patterns that differ in one unmasked bit;
- an all-ones mask;
- the same matching address with the strobe low.

For the data side, each source is driven with the matching word on the selected input and a mismatch on the others, and then the reverse. This shows that the source is really picked, rather than any input matching. For each memory port, the bench rewrites the unused register half between cycles to show that the half is ignored. An invalid source code is run with data compare on and then off, which tells the address-only path apart from the data path.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int REG_AW = 3;
    localparam int CTRL_W = 5;

    localparam logic [REG_AW-1:0] OFS_ADDR = 3'd0;
    localparam logic [REG_AW-1:0] OFS_MASK = 3'd1;
    localparam logic [REG_AW-1:0] OFS_DATA = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [DATA_W-1:0] data;
        logic [1:0]        code;
        logic              xy_en;
        logic              xy_sel;
        logic              data_en;
    } cfg_t;

    typedef enum logic [2:0] {
        SRC_A    = 3'd0,
        SRC_B    = 3'd1,
        SRC_X    = 3'd2,
        SRC_Y    = 3'd3,
        SRC_NONE = 3'd4
    } src_e;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            unique case (reg_addr)
                OFS_ADDR: cfg_d.addr = reg_wdata;
                OFS_MASK: cfg_d.mask = reg_wdata;
                OFS_DATA: cfg_d.data = reg_wdata;
                OFS_CTRL: begin
                    cfg_d.code    = reg_wdata[1:0];
                    cfg_d.xy_en   = reg_wdata[2];
                    cfg_d.xy_sel  = reg_wdata[3];
                    cfg_d.data_en = reg_wdata[4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_ADDR: reg_rdata = cfg_q.addr;
            OFS_MASK: reg_rdata = cfg_q.mask;
            OFS_DATA: reg_rdata = cfg_q.data;
            OFS_CTRL: reg_rdata[CTRL_W-1:0] = {cfg_q.data_en, cfg_q.xy_sel,
                                               cfg_q.xy_en, cfg_q.code};
            default:  reg_rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] cyc_addr,
    input  logic [W-1:0] ref_addr,
    input  logic [W-1:0] ign_mask,
    output logic         hit
);
    logic [W-1:0] diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = (cyc_addr[i] ^ ref_addr[i]) & ~ign_mask[i];
    end

    assign hit = ~|diff;
endmodule

// File: rtl/brk_data_match.sv
module brk_data_match
    import brk_pkg::*;
(
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] bus_a_data,
    input  logic [DATA_W-1:0] bus_b_data,
    input  logic [HALF_W-1:0] mem_x_data,
    input  logic [HALF_W-1:0] mem_y_data,
    output logic              hit
);
    src_e src;

    always_comb begin
        if (cfg.xy_en)             src = cfg.xy_sel ? SRC_Y : SRC_X;
        else if (cfg.code == 2'b00) src = SRC_A;
        else if (cfg.code == 2'b01) src = SRC_B;
        else                        src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_A:   hit = (bus_a_data == cfg.data);
            SRC_B:   hit = (bus_b_data == cfg.data);
            SRC_X:   hit = (mem_x_data == cfg.data[DATA_W-1 -: HALF_W]);
            SRC_Y:   hit = (mem_y_data == cfg.data[HALF_W-1:0]);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] bus_a_data,
    input  logic [DATA_W-1:0] bus_b_data,
    input  logic [HALF_W-1:0] mem_x_data,
    input  logic [HALF_W-1:0] mem_y_data,
    output logic              brk_pulse
);
    cfg_t cfg;
    logic addr_hit, data_hit;
    logic pulse_d, pulse_q;

    brk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg)
    );

    brk_addr_match #(.W(ADDR_W)) u_amatch (
        .cyc_addr(cyc_addr), .ref_addr(cfg.addr), .ign_mask(cfg.mask),
        .hit(addr_hit)
    );

    brk_data_match u_dmatch (
        .cfg(cfg), .bus_a_data(bus_a_data), .bus_b_data(bus_b_data),
        .mem_x_data(mem_x_data), .mem_y_data(mem_y_data), .hit(data_hit)
    );

    always_comb begin
        pulse_d = cyc_valid & addr_hit & (~cfg.data_en | data_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign brk_pulse = pulse_q;
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk
    import brk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              cyc_valid,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [HALF_W-1:0] mem_x_data,
    input logic [HALF_W-1:0] mem_y_data,
    input logic              brk_pulse,
    input cfg_t              cfg
);
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (brk_pulse == 1'b0 && cfg == '0)
                else $error("R1 reset state");
        end
    end

    p_addr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_ADDR) |=> cfg.addr == $past(reg_wdata));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_MASK) |=> cfg.mask == $past(reg_wdata));

    p_unmasked_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> ((($past(cyc_addr) ^ $past(cfg.addr)) & ~$past(cfg.mask)) == '0));

    p_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(cyc_valid));

    p_x_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pulse && $past(cfg.data_en && cfg.xy_en && !cfg.xy_sel))
        |-> $past(mem_x_data) == $past(cfg.data[DATA_W-1 -: HALF_W]));

    p_y_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pulse && $past(cfg.data_en && cfg.xy_en && cfg.xy_sel))
        |-> $past(mem_y_data) == $past(cfg.data[HALF_W-1:0]));

    p_no_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> !$past(cfg.data_en && !cfg.xy_en && cfg.code[1]));

    p_hole_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[2]) |=> $stable(cfg));
endmodule

bind brk_cmp brk_cmp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .mem_x_data(mem_x_data), .mem_y_data(mem_y_data),
    .brk_pulse(brk_pulse), .cfg(cfg)
);

// File: tb/sim_brk_cmp.sv
module sim_brk_cmp;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic [31:0] bus_a_data = '0;
    logic [31:0] bus_b_data = '0;
    logic [15:0] mem_x_data = '0;
    logic [15:0] mem_y_data = '0;
    logic        brk_pulse;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb[$];

    brk_cmp u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, {31'd0, brk_pulse}, {31'd0, it.exp});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; cyc_valid = 1'b0;
        sb.push_back('{1'b0, "R5 no pulse on write"});
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a; cyc_valid = 1'b0;
        sb.push_back('{1'b0, "R5 no pulse on read"});
        #1 check(tag, reg_rdata, exp);
    endtask

    task automatic cyc(input logic v, input logic [31:0] ad, input logic [31:0] da,
                       input logic [31:0] db, input logic [15:0] dx, input logic [15:0] dy,
                       input logic exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; cyc_valid = v; cyc_addr = ad;
        bus_a_data = da; bus_b_data = db; mem_x_data = dx; mem_y_data = dy;
        sb.push_back('{exp, tag});
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pulse low in reset", {31'd0, brk_pulse}, 32'd0);
        rst_n = 1'b1;
        rd(3'd0, 32'd0, "R1 address reset");
        rd(3'd1, 32'd0, "R1 mask reset");
        rd(3'd2, 32'd0, "R1 data reset");
        rd(3'd3, 32'd0, "R1 control reset");

        wr(3'd0, 32'h8000_1000);
        wr(3'd1, 32'h0000_00FF);
        wr(3'd2, 32'hDEAD_BEEF);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0, 32'h8000_1000, "R2 address readback");
        rd(3'd1, 32'h0000_00FF, "R2 mask readback");
        rd(3'd2, 32'hDEAD_BEEF, "R2 data readback");
        rd(3'd3, 32'h0000_001F, "R2 control upper bits zero");

        // address only
        wr(3'd3, 32'h0000_0000);
        cyc(1, 32'h8000_10AB, 0, 0, 0, 0, 1'b1, "R3 masked bits differ R9");
        cyc(0, 32'h8000_1000, 0, 0, 0, 0, 1'b0, "R5 pulse one clock wide");
        cyc(1, 32'h8000_1100, 0, 0, 0, 0, 1'b0, "R4 unmasked bit differs");
        cyc(0, 32'h8000_1000, 0, 0, 0, 0, 1'b0, "R5 no pulse without valid");
        cyc(1, 32'h0000_1000, 0, 0, 0, 0, 1'b0, "R4 top bit differs");

        // 32-bit buses
        wr(3'd3, 32'h0000_0010);
        cyc(1, 32'h8000_1000, 32'hDEAD_BEEF, 0, 0, 0, 1'b1, "R6 bus A match");
        cyc(1, 32'h8000_1000, 32'hDEAD_BEEE, 32'hDEAD_BEEF, 0, 0, 1'b0, "R6 bus A mismatch");
        wr(3'd3, 32'h0000_0011);
        cyc(1, 32'h8000_1000, 0, 32'hDEAD_BEEF, 0, 0, 1'b1, "R6 bus B match");
        cyc(1, 32'h8000_1000, 32'hDEAD_BEEF, 32'h5EAD_BEEF, 0, 0, 1'b0, "R6 bus B mismatch");

        // X port
        wr(3'd3, 32'h0000_0014);
        cyc(1, 32'h8000_1000, 0, 0, 16'hDEAD, 16'hBEEF, 1'b1, "R7 X upper match");
        cyc(1, 32'h8000_1000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'hBEEF, 16'hDEAD, 1'b0, "R7 X mismatch");
        wr(3'd2, 32'hDEAD_0000);
        cyc(1, 32'h8000_1000, 0, 0, 16'hDEAD, 16'h0000, 1'b1, "R7 lower half ignored");

        // Y port
        wr(3'd3, 32'h0000_001C);
        cyc(1, 32'h8000_1000, 0, 0, 16'hDEAD, 16'h0000, 1'b1, "R8 Y lower match");
        wr(3'd2, 32'h1234_BEEF);
        cyc(1, 32'h8000_1000, 0, 0, 16'h0000, 16'hBEEF, 1'b1, "R8 upper half ignored");
        cyc(1, 32'h8000_1000, 0, 0, 16'hBEEF, 16'h0000, 1'b0, "R8 Y mismatch");

        // no source, then address only
        wr(3'd2, 32'hCAFE_F00D);
        wr(3'd3, 32'h0000_0012);
        cyc(1, 32'h8000_1000, 32'hCAFE_F00D, 32'hCAFE_F00D, 16'hCAFE, 16'hF00D, 1'b0, "R10 code 10 no source");
        wr(3'd3, 32'h0000_0013);
        cyc(1, 32'h8000_1000, 32'hCAFE_F00D, 32'hCAFE_F00D, 16'hCAFE, 16'hF00D, 1'b0, "R10 code 11 no source");
        wr(3'd3, 32'h0000_0002);
        cyc(1, 32'h8000_1000, 0, 0, 0, 0, 1'b1, "R9 address only with bad code");

        // unmapped offsets
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, 32'd0, "R11 hole reads zero");
        rd(3'd0, 32'h8000_1000, "R11 address unchanged");
        rd(3'd1, 32'h0000_00FF, "R11 mask unchanged");
        rd(3'd3, 32'h0000_0002, "R11 control unchanged");

        // full mask
        wr(3'd1, 32'hFFFF_FFFF);
        cyc(1, 32'h1234_5678, 0, 0, 0, 0, 1'b1, "R3 all bits masked");
        cyc(1, 32'h1234_5678, 0, 0, 0, 0, 1'b1, "R5 back to back pulses");
        cyc(0, 32'h1234_5678, 0, 0, 0, 0, 1'b0, "R5 pulse drops");

        @(negedge clk);
        cyc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", sb.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule